// File: doc/BRIEF.md
# Windowed Register File

This block is a 32-bit general register file whose architectural view slides along a ring of overlapping windows. A five-bit register number selects one of 32 visible registers. Eight of them are globals, shared by every window. The other 24 belong to the current window: eight outgoing, eight private and eight incoming registers. The outgoing registers of one window occupy the same storage as the incoming registers of the window after it. A caller can therefore leave arguments in its outgoing registers, advance the window pointer, and have the callee find them in its incoming registers. No data is copied. On return the pointer steps back, and whatever the callee left in its incoming registers shows up in the caller's outgoing registers.

Seven windows share 56 ring-group registers and 56 private registers. With the eight globals, the bank holds 120 physical words. Each window has a bit in an input mask that marks it as unusable. An advance into a marked window, or a return into one, leaves the pointer where it was and raises a one-cycle trap request. The trap handler outside the block spills or refills the window and then clears the mask bit.

The block has two combinational read ports and one write port that updates on the clock edge. All three are translated through the current window pointer.

Top module: `rwin_regfile`

## Requirements
- R1: After reset the window pointer is 0, both trap requests are low and every architectural register reads as zero.
- R2: Register numbers 0 to 7 select the globals, which are the same storage in every window. Numbers 8 to 15 select the outgoing group, 16 to 23 the private group and 24 to 31 the incoming group.
- R3: Register number 0 always reads as zero on both read ports, and a write to it has no effect.
- R4: Outgoing register 8+k of window w is the same storage as incoming register 24+k of window (w+1) mod 7. A value written there before an advance reads back as an incoming register after the advance.
- R5: After a return, a value the callee wrote into incoming register 24+k reads back as the caller's outgoing register 8+k.
- R6: Private registers 16 to 23 of one window are storage that no other window can reach.
- R7: An accepted advance sets the pointer to (cwp+1) mod 7, so 6 goes to 0. An accepted return sets it to (cwp+6) mod 7, so 0 goes to 6. With neither request the pointer holds.
- R8: If bit (cwp+1) mod 7 of the invalid mask is 1 during an advance, the pointer is unchanged and the overflow trap output is 1 in the following cycle only.
- R9: If bit (cwp+6) mod 7 of the invalid mask is 1 during a return, the pointer is unchanged and the underflow trap output is 1 in the following cycle only.
- R10: When advance and return are requested in the same cycle, the advance is acted on and the return is ignored. The two trap outputs are never high together.
- R11: A write in the same cycle as a window change is placed using the pointer value from before the change.
- R12: The read ports are combinational and independent. A write becomes visible on the read ports after the clock edge that takes it, and a read of the same register in the write cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 32 | Write data |
| win_adv | input | 1 | Advance request (call / context switch) |
| win_ret | input | 1 | Return request |
| win_invalid | input | 7 | One bit per window; 1 marks the window unusable |
| cwp | output | 3 | Current window pointer |
| ovf_trap | output | 1 | Overflow trap request, one-cycle pulse |
| unf_trap | output | 1 | Underflow trap request, one-cycle pulse |

## Verification
A register write and a window move can share a clock edge. The write must then land in the window that was current before the move, and this is where a wrong window is most likely to be chosen. The bench provokes this on purpose: it writes an outgoing or incoming register in the same cycle as an advance or a return. It then reads the opposite group in the new window and judges the result against a bench model that places the write first and moves the pointer afterwards. The random phase draws writes and pointer requests independently, often together, with a sparse random invalid mask, so that collisions, trap cases and simultaneous advance and return requests recur many times.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

   // Architectural register groups; the two high address bits decode to these.
   typedef enum logic [1:0] {
      GRP_GLOB = 2'd0,
      GRP_OUT  = 2'd1,
      GRP_LOC  = 2'd2,
      GRP_IN   = 2'd3
   } rwin_grp_e;

   localparam int unsigned NUM_GRP = 4;

endpackage

// File: rtl/rwin_addr_map.sv
module rwin_addr_map
   import rwin_pkg::*;
#(
   parameter int NWIN = 7,
   parameter int GRP  = 8,
   parameter int CW   = $clog2(NWIN),
   parameter int AW   = $clog2(GRP) + 2,
   parameter int PW   = $clog2(GRP + 2 * NWIN * GRP)
) (
   input  logic [CW-1:0] cwp,
   input  logic [AW-1:0] arch,
   output logic [PW-1:0] phys
);
   localparam int GB       = $clog2(GRP);
   localparam int RING_BASE = GRP;
   localparam int PRIV_BASE = GRP + NWIN * GRP;

   logic [CW-1:0] prev_w;
   int            base;

   always_comb begin
      prev_w = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
      unique case (rwin_grp_e'(arch[AW-1:GB]))
         GRP_GLOB: base = 0;
         GRP_OUT:  base = RING_BASE + int'(cwp) * GRP;
         GRP_IN:   base = RING_BASE + int'(prev_w) * GRP;
         default:  base = PRIV_BASE + int'(cwp) * GRP;
      endcase
      phys = PW'(base + int'(arch[GB-1:0]));
   end

endmodule

// File: rtl/rwin_cwp_ctrl.sv
module rwin_cwp_ctrl #(
   parameter int NWIN = 7,
   parameter int CW   = $clog2(NWIN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   input  logic            ret,
   input  logic [NWIN-1:0] invalid,
   output logic [CW-1:0]   cwp,
   output logic            ovf,
   output logic            unf
);
   logic [CW-1:0] cwp_q;
   logic [CW-1:0] next_w;
   logic [CW-1:0] prev_w;
   logic          adv_blocked;
   logic          ret_blocked;

   always_comb begin
      next_w      = (cwp_q == CW'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
      prev_w      = (cwp_q == '0) ? CW'(NWIN - 1) : cwp_q - 1'b1;
      adv_blocked = invalid[next_w];
      ret_blocked = invalid[prev_w];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cwp_q <= '0;
         ovf   <= 1'b0;
         unf   <= 1'b0;
      end else begin
         ovf <= 1'b0;
         unf <= 1'b0;
         if (adv) begin
            if (adv_blocked) ovf   <= 1'b1;
            else             cwp_q <= next_w;
         end else if (ret) begin
            if (ret_blocked) unf   <= 1'b1;
            else             cwp_q <= prev_w;
         end
      end
   end

   assign cwp = cwp_q;

endmodule

// File: rtl/rwin_bank.sv
module rwin_bank #(
   parameter int DATA_W         = 32,
   parameter int NPHYS          = 120,
   parameter int PW             = $clog2(NPHYS),
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PW-1:0]     wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PW-1:0]     rd_idx_a,
   input  logic [PW-1:0]     rd_idx_b,
   output logic [DATA_W-1:0] rd_data_a,
   output logic [DATA_W-1:0] rd_data_b
);
   logic [DATA_W-1:0] mem [NPHYS];
   logic              wr_ok;

   // Physical slot 0 is the hard-wired zero register.
   assign wr_ok = we && (wr_idx != '0);

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
            end else if (wr_ok) begin
               mem[wr_idx] <= wr_data;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (wr_ok) mem[wr_idx] <= wr_data;
         end
      end
   endgenerate

   assign rd_data_a = (rd_idx_a == '0) ? '0 : mem[rd_idx_a];
   assign rd_data_b = (rd_idx_b == '0) ? '0 : mem[rd_idx_b];

endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
   import rwin_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter int NWIN           = 7,
   parameter int GRP            = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [$clog2(GRP)+1:0]       rd_addr_a,
   output logic [DATA_W-1:0]            rd_data_a,
   input  logic [$clog2(GRP)+1:0]       rd_addr_b,
   output logic [DATA_W-1:0]            rd_data_b,
   input  logic                         wr_en,
   input  logic [$clog2(GRP)+1:0]       wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic                         win_adv,
   input  logic                         win_ret,
   input  logic [NWIN-1:0]              win_invalid,
   output logic [$clog2(NWIN)-1:0]      cwp,
   output logic                         ovf_trap,
   output logic                         unf_trap
);
   localparam int AW     = $clog2(GRP) + 2;
   localparam int CW     = $clog2(NWIN);
   localparam int NPHYS  = GRP + 2 * NWIN * GRP;
   localparam int PW     = $clog2(NPHYS);
   localparam int NPORT  = 3;   // read A, read B, write

   generate
      if (GRP < 2 || (GRP & (GRP - 1)) != 0) begin : g_bad_grp
         $error("GRP must be a power of two, at least 2");
      end
      if (NWIN < 3) begin : g_bad_nwin
         $error("NWIN must be at least 3");
      end
      if (DATA_W < 1) begin : g_bad_w
         $error("DATA_W must be positive");
      end
   endgenerate

   logic [AW-1:0] arch_addr [NPORT];
   logic [PW-1:0] phys_idx  [NPORT];

   assign arch_addr[0] = rd_addr_a;
   assign arch_addr[1] = rd_addr_b;
   assign arch_addr[2] = wr_addr;

   rwin_cwp_ctrl #(
      .NWIN (NWIN),
      .CW   (CW)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (win_adv),
      .ret     (win_ret),
      .invalid (win_invalid),
      .cwp     (cwp),
      .ovf     (ovf_trap),
      .unf     (unf_trap)
   );

   // All ports translate through the registered pointer, so a write that
   // shares an edge with a window move lands in the old window.
   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_map
         rwin_addr_map #(
            .NWIN (NWIN),
            .GRP  (GRP),
            .CW   (CW),
            .AW   (AW),
            .PW   (PW)
         ) u_map (
            .cwp  (cwp),
            .arch (arch_addr[p]),
            .phys (phys_idx[p])
         );
      end
   endgenerate

   rwin_bank #(
      .DATA_W         (DATA_W),
      .NPHYS          (NPHYS),
      .PW             (PW),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (wr_en),
      .wr_idx    (phys_idx[2]),
      .wr_data   (wr_data),
      .rd_idx_a  (phys_idx[0]),
      .rd_idx_b  (phys_idx[1]),
      .rd_data_a (rd_data_a),
      .rd_data_b (rd_data_b)
   );

endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
   parameter int DATA_W = 32,
   parameter int NWIN   = 7,
   parameter int GRP    = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [$clog2(GRP)+1:0]  rd_addr_a,
   input logic [DATA_W-1:0]       rd_data_a,
   input logic [$clog2(GRP)+1:0]  rd_addr_b,
   input logic [DATA_W-1:0]       rd_data_b,
   input logic                    win_adv,
   input logic                    win_ret,
   input logic [NWIN-1:0]         win_invalid,
   input logic [$clog2(NWIN)-1:0] cwp,
   input logic                    ovf_trap,
   input logic                    unf_trap
);
   localparam int CW = $clog2(NWIN);

   logic [CW-1:0] nxt;
   logic [CW-1:0] prv;
   assign nxt = (cwp == CW'(NWIN - 1)) ? '0 : cwp + 1'b1;
   assign prv = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;

   assert_cwp_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cwp) < NWIN);

   assert_adv_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (win_adv && !win_invalid[nxt]) |=> (cwp == $past(nxt)) && !ovf_trap);

   assert_ret_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_adv && win_ret && !win_invalid[prv]) |=> (cwp == $past(prv)) && !unf_trap);

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_adv && !win_ret) |=> $stable(cwp) && !ovf_trap && !unf_trap);

   assert_no_overflow_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (win_adv && win_invalid[nxt]) |=> ovf_trap && $stable(cwp));

   assert_no_underflow_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_adv && win_ret && win_invalid[prv]) |=> unf_trap && $stable(cwp));

   assert_traps_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_trap && unf_trap));

   assert_zero_reg_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_a == '0) |-> (rd_data_a == '0));

   assert_zero_reg_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_b == '0) |-> (rd_data_b == '0));

endmodule

bind rwin_regfile rwin_regfile_chk #(
   .DATA_W (DATA_W),
   .NWIN   (NWIN),
   .GRP    (GRP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_addr_a   (rd_addr_a),
   .rd_data_a   (rd_data_a),
   .rd_addr_b   (rd_addr_b),
   .rd_data_b   (rd_data_b),
   .win_adv     (win_adv),
   .win_ret     (win_ret),
   .win_invalid (win_invalid),
   .cwp         (cwp),
   .ovf_trap    (ovf_trap),
   .unf_trap    (unf_trap)
);

// File: tb/rwin_regfile_tb.sv
module rwin_regfile_tb;
   localparam int CLK_T = 20;   // 50 MHz
   localparam int NW    = 7;
   localparam int NP    = 120;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        wr_en = 1'b0, win_adv = 1'b0, win_ret = 1'b0;
   logic [6:0]  win_invalid = '0;
   logic [31:0] rd_data_a, rd_data_b;
   logic [2:0]  cwp;
   logic        ovf_trap, unf_trap;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] ref_mem [NP];
   int          cwp_m = 0;
   bit          exp_ovf = 0, exp_unf = 0;

   always #(CLK_T/2) clk = ~clk;

   rwin_regfile u_dut (
      .clk(clk), .rst_n(rst_n),
      .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
      .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .win_adv(win_adv), .win_ret(win_ret), .win_invalid(win_invalid),
      .cwp(cwp), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
   );

   // Physical slot per R2/R4/R6: globals, ring groups, private groups.
   function automatic int pmap(int w, int a);
      int o = a % 8;
      case (a / 8)
         0:       return a;
         1:       return 8 + w * 8 + o;
         3:       return 8 + ((w + NW - 1) % NW) * 8 + o;
         default: return 8 + NW * 8 + w * 8 + o;
      endcase
   endfunction

   function automatic logic [31:0] exp_read(int a);
      return (a == 0) ? 32'h0 : ref_mem[pmap(cwp_m, a)];
   endfunction

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic step(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                       input logic adv, input logic ret, input logic [6:0] msk,
                       input logic [4:0] ra, input logic [4:0] rb, input string tag);
      int nxt, prv;
      @(negedge clk);
      chk(cwp == 3'(cwp_m), tag, "cwp", 32'(cwp), 32'(cwp_m));
      chk(ovf_trap == exp_ovf, (tag == "R1") ? "R1" : "R8", "ovf_trap", 32'(ovf_trap), 32'(exp_ovf));
      chk(unf_trap == exp_unf, (tag == "R1") ? "R1" : "R9", "unf_trap", 32'(unf_trap), 32'(exp_unf));
      wr_en = we; wr_addr = wa; wr_data = wd;
      win_adv = adv; win_ret = ret; win_invalid = msk;
      rd_addr_a = ra; rd_addr_b = rb;
      #5;
      chk(rd_data_a == exp_read(ra), tag, $sformatf("port A reg %0d", ra), rd_data_a, exp_read(ra));
      chk(rd_data_b == exp_read(rb), tag, $sformatf("port B reg %0d", rb), rd_data_b, exp_read(rb));
      // Model the edge: write with the old pointer (R11), then move (R7..R10).
      if (we && wa != 0) ref_mem[pmap(cwp_m, wa)] = wd;
      nxt = (cwp_m + 1) % NW;
      prv = (cwp_m + NW - 1) % NW;
      exp_ovf = 0; exp_unf = 0;
      if (adv) begin
         if (msk[nxt]) exp_ovf = 1; else cwp_m = nxt;
      end else if (ret) begin
         if (msk[prv]) exp_unf = 1; else cwp_m = prv;
      end
   endtask

   task automatic idle_read(input logic [4:0] ra, input logic [4:0] rb, input string tag);
      step(1'b0, 5'd0, 32'h0, 1'b0, 1'b0, 7'h0, ra, rb, tag);
   endtask

   initial begin
      #(CLK_T * 200000);
      n_bad++;
      $display("FAIL watchdog run did not finish");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h1D5EED));
      for (int i = 0; i < NP; i++) ref_mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state on every register number
      for (int a = 0; a < 32; a += 2) idle_read(5'(a), 5'(a + 1), "R1");

      // R3: writes to register 0 are dropped
      step(1'b1, 5'd0, 32'hDEADBEEF, 1'b0, 1'b0, 7'h0, 5'd0, 5'd0, "R3");
      idle_read(5'd0, 5'd0, "R3");

      // R12: same-cycle read returns old value, next cycle the new one
      step(1'b1, 5'd20, 32'hA5A5_0001, 1'b0, 1'b0, 7'h0, 5'd20, 5'd20, "R12");
      idle_read(5'd20, 5'd3, "R12");

      // R2: a global stays visible after moving windows
      step(1'b1, 5'd5, 32'h6106_0005, 1'b0, 1'b0, 7'h0, 5'd5, 5'd0, "R2");
      step(1'b0, 5'd0, 32'h0, 1'b1, 1'b0, 7'h0, 5'd5, 5'd0, "R2");
      idle_read(5'd5, 5'd13, "R2");

      // R11 + R4: write an outgoing register in the advance cycle
      step(1'b1, 5'd9, 32'hCA11_0009, 1'b1, 1'b0, 7'h0, 5'd9, 5'd25, "R11");
      idle_read(5'd25, 5'd9, "R4");

      // R6: private register not reachable from the neighbour window
      step(1'b1, 5'd17, 32'h10CA_1017, 1'b0, 1'b0, 7'h0, 5'd17, 5'd0, "R6");
      step(1'b0, 5'd0, 32'h0, 1'b1, 1'b0, 7'h0, 5'd17, 5'd0, "R6");
      idle_read(5'd17, 5'd18, "R6");

      // R5 + R11: callee writes an incoming register in the return cycle
      step(1'b1, 5'd26, 32'hBAC4_0026, 1'b0, 1'b1, 7'h0, 5'd26, 5'd10, "R5");
      idle_read(5'd10, 5'd26, "R5");

      // R7: wrap forward past window 6 and backward past window 0
      for (int k = 0; k < NW; k++) step(1'b0, 5'd0, 32'h0, 1'b1, 1'b0, 7'h0, 5'd9, 5'd25, "R7");
      for (int k = 0; k < NW + 2; k++) step(1'b0, 5'd0, 32'h0, 1'b0, 1'b1, 7'h0, 5'd10, 5'd26, "R7");

      // R8: advance into a marked window
      step(1'b0, 5'd0, 32'h0, 1'b1, 1'b0, 7'h7F, 5'd1, 5'd2, "R8");
      idle_read(5'd1, 5'd2, "R8");
      // R9: return into a marked window
      step(1'b0, 5'd0, 32'h0, 1'b0, 1'b1, 7'h7F, 5'd1, 5'd2, "R9");
      idle_read(5'd1, 5'd2, "R9");
      // R10: both requests at once, advance wins; then both with advance blocked
      step(1'b0, 5'd0, 32'h0, 1'b1, 1'b1, 7'h00, 5'd1, 5'd2, "R10");
      step(1'b0, 5'd0, 32'h0, 1'b1, 1'b1, 7'h7F, 5'd1, 5'd2, "R10");
      idle_read(5'd1, 5'd2, "R10");

      // Random mix of writes, moves and sparse invalid masks
      for (int n = 0; n < 4000; n++) begin
         logic [6:0] m;
         int r;
         r = int'($urandom % 8);
         m = (r == 0) ? 7'($urandom) : ((r == 1) ? 7'h7F : 7'h00);
         step(1'($urandom), 5'($urandom), $urandom,
              ($urandom % 3) == 0, ($urandom % 3) == 0, m,
              5'($urandom), 5'($urandom), "R2");
      end
      idle_read(5'd8, 5'd24, "R2");

      summary();
      $finish;
   end

endmodule